// File: doc/BRIEF.md
# DDR Region Security Filter

This block decides, for every memory access, whether the target address lies in memory marked as secure and whether the requester is allowed to touch it. Eight programmable address windows, each expressed in whole megabytes with an inclusive upper bound, can be marked secure one by one. A separate switch marks everything that falls outside all eight windows as secure. A global bypass switch overrides all of it and makes the whole address space non-secure.

Configuration arrives on a simple 32-bit write port. The lower half of each written word is data. The upper half is a per-bit write-enable: a data bit is updated only where its enable bit is 1. Word indices 0..7 hold the window lower bounds, 8..15 the window upper bounds, 16 the control word and 17 the error-clear strobe.

The check port takes a byte address and a secure/non-secure attribute. One cycle later the block returns a response valid strobe and an allow/deny result. A denial raises a sticky error flag and records the offending address.

Top module: `ddr_region_filter`

## Requirements
- R1: Synchronous reset leaves the control word with bypass = 1 (bit 9) and all enables = 0, all window bounds = 0, the error flag cleared, the error address = 0 and `resp_valid` low. As a result every access is allowed after reset.
- R2: A write changes a lower data bit `i` of the addressed word only when `cfg_wdata[16+i]` is 1. Bits whose enable is 0 keep their value. Window bound words keep bits [11:0] and the control word keeps bits [9:0]; higher data bits are dropped.
- R3: Window `n` has its lower bound in word `n` and its upper bound in word `n+8`, both counted in megabytes (address bits [31:20]). It covers megabyte `m` when lower <= m <= upper, so bounds 0 and 0 cover bytes 0x0 to 0xFFFFF only.
- R4: Control bit `n` (bits 0..7) marks window `n` as secure; a window whose bit is 0 adds no protection.
- R5: Control bit 8 marks as secure every address that lies inside none of the eight windows. The test uses the stored bounds whether or not a window is enabled.
- R6: When control bit 9 (bypass) is 1, every access is allowed.
- R7: An access with `chk_secure` = 1 is always allowed. A non-secure access to a secure address is denied.
- R8: When windows overlap, an address is secure if any enabled window containing it is secure.
- R9: `resp_valid` and `resp_allow` for a check presented on one clock edge appear after that edge and stay for one cycle. `resp_valid` is low in any cycle that follows an edge without `chk_valid`.
- R10: A denial sets `err_flag`, which stays set until cleared. `err_addr` records the address of the denial that set the flag; later denials while the flag is set leave it unchanged.
- R11: Writing word 17 with data bit 0 = 1 and enable bit 16 = 1 clears `err_flag`. When a denial occurs in the same cycle as the clear, the flag stays set and `err_addr` takes the new address.
- R12: A window whose lower bound exceeds its upper bound covers no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word index (0..17) |
| cfg_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| chk_valid | input | 1 | Access check request |
| chk_secure | input | 1 | Requester attribute, 1 = secure |
| chk_addr | input | 32 | Byte address to check |
| resp_valid | output | 1 | Check response strobe |
| resp_allow | output | 1 | 1 = access allowed, 0 = denied |
| err_flag | output | 1 | Sticky denial flag |
| err_addr | output | 32 | Address of the denial that set the flag |

## Verification
Every result of a check (response strobe, allow bit, error flag and error address) is due on the first rising edge after the check inputs are presented. A configuration write lands on that same edge, so it affects only checks presented in later cycles. The bench drives each cycle's inputs on the falling edge and samples 1 ns after the next rising edge. Its reference model evaluates the check against the configuration as it stood before that edge, and only then applies the write, so the same-cycle write and check cases line up exactly.

// File: rtl/ddr_rgn_pkg.sv
package ddr_rgn_pkg;

    localparam int RGN_NUM  = 8;
    localparam int ADDR_W   = 32;
    localparam int MB_SHIFT = 20;
    localparam int HALF_W   = 16;

    // Role of a configuration word index
    typedef enum logic [2:0] {
        WK_LOWER,
        WK_UPPER,
        WK_CTRL,
        WK_CLEAR,
        WK_NONE
    } word_kind_e;

    typedef struct packed {
        logic              valid;
        logic              secure;
        logic [ADDR_W-1:0] addr;
    } chk_req_t;

    function automatic word_kind_e classify_word(int idx, int nrgn);
        if (idx < nrgn)               return WK_LOWER;
        else if (idx < 2 * nrgn)      return WK_UPPER;
        else if (idx == 2 * nrgn)     return WK_CTRL;
        else if (idx == 2 * nrgn + 1) return WK_CLEAR;
        else                          return WK_NONE;
    endfunction

    // Upper half of the written word selects which lower bits change
    function automatic logic [HALF_W-1:0] merge_masked(logic [HALF_W-1:0] old_v,
                                                       logic [2*HALF_W-1:0] wr);
        return (old_v & ~wr[2*HALF_W-1:HALF_W]) | (wr[HALF_W-1:0] & wr[2*HALF_W-1:HALF_W]);
    endfunction

endpackage

// File: rtl/ddr_rgn_cfg.sv
module ddr_rgn_cfg
    import ddr_rgn_pkg::*;
#(
    parameter int N_RGN  = 8,
    parameter int MB_W   = 12,
    parameter int CFG_AW = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [2*HALF_W-1:0]         cfg_wdata,
    output logic [N_RGN-1:0][MB_W-1:0]  lower_q,
    output logic [N_RGN-1:0][MB_W-1:0]  upper_q,
    output logic [N_RGN-1:0]            enable_q,
    output logic                        outside_q,
    output logic                        bypass_q,
    output logic                        clear_pulse
);
    localparam int CTRL_W = N_RGN + 2;

    word_kind_e kind;
    logic [CTRL_W-1:0] ctrl_q;
    logic [HALF_W-1:0] ctrl_merged;

    always_comb begin
        kind = classify_word(int'(cfg_addr), N_RGN);
    end

    genvar g;
    generate
        for (g = 0; g < N_RGN; g++) begin : g_rgn
            logic [HALF_W-1:0] lo_merged;
            logic [HALF_W-1:0] hi_merged;
            logic wr_lo;
            logic wr_hi;
            assign wr_lo     = cfg_we && (cfg_addr == CFG_AW'(g));
            assign wr_hi     = cfg_we && (cfg_addr == CFG_AW'(g + N_RGN));
            assign lo_merged = merge_masked(HALF_W'(lower_q[g]), cfg_wdata);
            assign hi_merged = merge_masked(HALF_W'(upper_q[g]), cfg_wdata);
            always_ff @(posedge clk) begin
                if (rst) begin
                    lower_q[g] <= '0;
                    upper_q[g] <= '0;
                end else begin
                    if (wr_lo) lower_q[g] <= lo_merged[MB_W-1:0];
                    if (wr_hi) upper_q[g] <= hi_merged[MB_W-1:0];
                end
            end
        end
    endgenerate

    assign ctrl_merged = merge_masked(HALF_W'(ctrl_q), cfg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_W'(1) << (N_RGN + 1);
        end else if (cfg_we && kind == WK_CTRL) begin
            ctrl_q <= ctrl_merged[CTRL_W-1:0];
        end
    end

    assign enable_q    = ctrl_q[N_RGN-1:0];
    assign outside_q   = ctrl_q[N_RGN];
    assign bypass_q    = ctrl_q[N_RGN+1];
    assign clear_pulse = cfg_we && (kind == WK_CLEAR) && cfg_wdata[HALF_W] && cfg_wdata[0];

    // R2: a control write with an all-zero enable half changes nothing
    a_r2_ctrl_masked_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && kind == WK_CTRL && cfg_wdata[2*HALF_W-1:HALF_W] == '0) |=> $stable(ctrl_q))
        else $error("a_r2_ctrl_masked_hold");

    // R2: writes to other words leave the control word alone
    a_r2_ctrl_other_hold: assert property (@(posedge clk) disable iff (rst)
        (!(cfg_we && kind == WK_CTRL)) |=> $stable(ctrl_q))
        else $error("a_r2_ctrl_other_hold");

endmodule

// File: rtl/ddr_rgn_match.sv
module ddr_rgn_match #(
    parameter int N_RGN = 8,
    parameter int MB_W  = 12
) (
    input  logic [MB_W-1:0]             mb,
    input  logic [N_RGN-1:0][MB_W-1:0]  lower_q,
    input  logic [N_RGN-1:0][MB_W-1:0]  upper_q,
    output logic [N_RGN-1:0]            hit,
    output logic                        any_in
);
    genvar g;
    generate
        for (g = 0; g < N_RGN; g++) begin : g_cmp
            // inclusive bounds; lower > upper yields no coverage
            assign hit[g] = (mb >= lower_q[g]) && (mb <= upper_q[g]);
        end
    endgenerate

    assign any_in = |hit;

endmodule

// File: rtl/ddr_rgn_judge.sv
module ddr_rgn_judge
    import ddr_rgn_pkg::*;
#(
    parameter int N_RGN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  chk_req_t           req,
    input  logic [N_RGN-1:0]   hit,
    input  logic               any_in,
    input  logic [N_RGN-1:0]   enable_q,
    input  logic               outside_q,
    input  logic               bypass_q,
    input  logic               clear_pulse,
    output logic               resp_valid,
    output logic               resp_allow,
    output logic               err_flag,
    output logic [ADDR_W-1:0]  err_addr
);
    logic addr_secure;
    logic deny;

    always_comb begin
        addr_secure = !bypass_q && ((|(hit & enable_q)) || (outside_q && !any_in));
        deny        = req.valid && !req.secure && addr_secure;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b1;
            err_flag   <= 1'b0;
            err_addr   <= '0;
        end else begin
            resp_valid <= req.valid;
            resp_allow <= !deny;
            if (deny && (!err_flag || clear_pulse)) err_addr <= req.addr;
            err_flag <= deny || (err_flag && !clear_pulse);
        end
    end

    // R9: response strobe follows the request by one edge
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> resp_valid) else $error("a_r9_resp_follows");
    a_r9_resp_idle: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> !resp_valid) else $error("a_r9_resp_idle");
    // R7: secure requesters always pass
    a_r7_secure_pass: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.secure) |=> resp_allow) else $error("a_r7_secure_pass");
    // R6: bypass passes everything
    a_r6_bypass_pass: assert property (@(posedge clk) disable iff (rst)
        (req.valid && bypass_q) |=> resp_allow) else $error("a_r6_bypass_pass");
    // R10: flag is sticky and its address frozen without a clear
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clear_pulse) |=> err_flag) else $error("a_r10_flag_sticky");
    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clear_pulse) |=> $stable(err_addr)) else $error("a_r10_addr_frozen");
    a_r10_deny_flags: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_allow) |-> err_flag) else $error("a_r10_deny_flags");
    // R11: a clear with no competing denial drops the flag
    a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clear_pulse && !deny) |=> !err_flag) else $error("a_r11_clear_drops");

endmodule

// File: rtl/ddr_region_filter.sv
module ddr_region_filter
    import ddr_rgn_pkg::*;
#(
    parameter int N_RGN    = RGN_NUM,
    parameter int MBSHIFT  = MB_SHIFT,
    parameter int CFG_AW   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              chk_valid,
    input  logic              chk_secure,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int MB_W = ADDR_W - MBSHIFT;

    logic [N_RGN-1:0][MB_W-1:0] lower_q;
    logic [N_RGN-1:0][MB_W-1:0] upper_q;
    logic [N_RGN-1:0]           enable_q;
    logic                       outside_q;
    logic                       bypass_q;
    logic                       clear_pulse;
    logic [N_RGN-1:0]           hit;
    logic                       any_in;
    chk_req_t                   req;

    assign req.valid  = chk_valid;
    assign req.secure = chk_secure;
    assign req.addr   = chk_addr;

    ddr_rgn_cfg #(.N_RGN(N_RGN), .MB_W(MB_W), .CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lower_q(lower_q), .upper_q(upper_q), .enable_q(enable_q),
        .outside_q(outside_q), .bypass_q(bypass_q), .clear_pulse(clear_pulse)
    );

    ddr_rgn_match #(.N_RGN(N_RGN), .MB_W(MB_W)) u_match (
        .mb(chk_addr[ADDR_W-1:MBSHIFT]), .lower_q(lower_q), .upper_q(upper_q),
        .hit(hit), .any_in(any_in)
    );

    ddr_rgn_judge #(.N_RGN(N_RGN)) u_judge (
        .clk(clk), .rst(rst), .req(req), .hit(hit), .any_in(any_in),
        .enable_q(enable_q), .outside_q(outside_q), .bypass_q(bypass_q),
        .clear_pulse(clear_pulse), .resp_valid(resp_valid), .resp_allow(resp_allow),
        .err_flag(err_flag), .err_addr(err_addr)
    );

    // R1: the cycle after reset releases, the block is in bypass with no error
    a_r1_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (bypass_q && enable_q == '0 && !outside_q && !err_flag && !resp_valid))
        else $error("a_r1_reset_state");

endmodule

// File: tb/test_ddr_region_filter.sv
`timescale 1ns/1ps
module test_ddr_region_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        chk_valid;
    logic        chk_secure;
    logic [31:0] chk_addr;
    logic        resp_valid;
    logic        resp_allow;
    logic        err_flag;
    logic [31:0] err_addr;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    logic [11:0] m_lo [8];
    logic [11:0] m_hi [8];
    logic [9:0]  m_ctrl;
    logic        m_err;
    logic [31:0] m_eaddr;

    always #2.5 clk = ~clk;

    ddr_region_filter i_ddr_region_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .chk_valid(chk_valid), .chk_secure(chk_secure), .chk_addr(chk_addr),
        .resp_valid(resp_valid), .resp_allow(resp_allow),
        .err_flag(err_flag), .err_addr(err_addr)
    );

    function automatic logic [15:0] mmerge(logic [15:0] old_v, logic [31:0] wd);
        return (old_v & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    endfunction

    function automatic bit model_deny(logic [31:0] a, bit sec);
        logic [11:0] mb;
        bit any_in;
        bit prot;
        mb = a[31:20];
        any_in = 0;
        prot = 0;
        if (m_ctrl[9] || sec) return 0;
        for (int i = 0; i < 8; i++) begin
            if (mb >= m_lo[i] && mb <= m_hi[i]) begin
                any_in = 1;
                if (m_ctrl[i]) prot = 1;
            end
        end
        if (!any_in && m_ctrl[8]) prot = 1;
        return prot;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(bit we, int wa, logic [31:0] wd, bit cv, logic [31:0] ca, bit cs, string req);
        bit d;
        bit clr;
        logic [15:0] t;
        @(negedge clk);
        cfg_we = we; cfg_addr = 5'(wa); cfg_wdata = wd;
        chk_valid = cv; chk_addr = ca; chk_secure = cs;
        d = cv && model_deny(ca, cs);
        clr = we && wa == 17 && wd[16] && wd[0];
        if (we) begin
            if (wa < 8) begin
                t = mmerge({4'b0, m_lo[wa]}, wd); m_lo[wa] = t[11:0];
            end else if (wa < 16) begin
                t = mmerge({4'b0, m_hi[wa-8]}, wd); m_hi[wa-8] = t[11:0];
            end else if (wa == 16) begin
                t = mmerge({6'b0, m_ctrl}, wd); m_ctrl = t[9:0];
            end
        end
        if (d && (!m_err || clr)) m_eaddr = ca;
        m_err = d || (m_err && !clr);
        @(posedge clk);
        #1;
        check({req, " resp_valid"}, 32'(resp_valid), 32'(cv));
        if (cv) check({req, " resp_allow"}, 32'(resp_allow), 32'(!d));
        check({req, " err_flag"}, 32'(err_flag), 32'(m_err));
        check({req, " err_addr"}, err_addr, m_eaddr);
    endtask

    task automatic wr(int wa, logic [31:0] wd, string req);
        step(1, wa, wd, 0, 32'h0, 0, req);
    endtask

    task automatic ck(logic [31:0] a, bit s, string req);
        step(0, 0, 32'h0, 1, a, s, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240917));
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        chk_valid = 0; chk_secure = 0; chk_addr = 0;
        for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
        m_ctrl = 10'h200; m_err = 0; m_eaddr = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset resp_valid", 32'(resp_valid), 0);
        check("R1 reset err_flag", 32'(err_flag), 0);
        check("R1 reset err_addr", err_addr, 0);
        @(negedge clk); rst = 0;

        // R1 / R6: bypass after reset allows everything
        ck(32'h0000_0000, 0, "R1 bypass after reset");
        ck(32'h7FF0_0000, 0, "R1 bypass high address");

        // R3 / R4: window 0 = MB 0..0
        wr(0, 32'hFFFF_0000, "R3 lower0");
        wr(8, 32'hFFFF_0000, "R3 upper0");
        wr(16, 32'hFFFF_0001, "R4 enable window 0");
        ck(32'h000F_FFFF, 0, "R3 R4 last byte of MB0 denied");
        ck(32'h0010_0000, 0, "R3 first byte of MB1 allowed");
        ck(32'h0000_0000, 1, "R7 secure access allowed");
        ck(32'h0000_0010, 0, "R10 second denial keeps address");
        step(0, 0, 32'h0, 0, 32'h0, 0, "R9 idle cycle no response");
        wr(17, 32'h0000_0001, "R11 clear without enable ignored");
        wr(17, 32'h0001_0001, "R11 clear");

        // R2: masked writes on the upper bound of window 0
        wr(8, 32'h0000_000A, "R2 all-masked write");
        ck(32'h0050_0000, 0, "R2 bound unchanged");
        wr(8, 32'h0002_000A, "R2 single-bit write");
        ck(32'h0020_0000, 0, "R2 MB2 now inside");
        ck(32'h0030_0000, 0, "R2 MB3 outside");
        wr(17, 32'h0001_0001, "R11 clear");

        // R5: only the outside switch
        wr(16, 32'hFFFF_0100, "R5 outside only");
        ck(32'h0030_0000, 0, "R5 outside address denied");
        ck(32'h0000_0000, 0, "R5 disabled window not protected");
        // R6: bypass with everything on
        wr(16, 32'hFFFF_03FF, "R6 bypass on");
        ck(32'h0030_0000, 0, "R6 bypass allows");
        ck(32'h0000_0000, 0, "R6 bypass allows window");

        // R8: overlap of window 1 (1..5) and window 2 (3..4)
        wr(1, 32'hFFFF_0001, "R8 lower1");
        wr(9, 32'hFFFF_0005, "R8 upper1");
        wr(2, 32'hFFFF_0003, "R8 lower2");
        wr(10, 32'hFFFF_0004, "R8 upper2");
        wr(16, 32'hFFFF_0002, "R8 enable window 1 only");
        ck(32'h0030_0000, 0, "R8 overlap enabled window wins");
        wr(16, 32'hFFFF_0004, "R8 enable window 2 only");
        ck(32'h0030_0000, 0, "R8 inner window denies");
        ck(32'h0050_0000, 0, "R8 outer-only address allowed");

        // R12: inverted window 3 (9..7)
        wr(3, 32'hFFFF_0009, "R12 lower3");
        wr(11, 32'hFFFF_0007, "R12 upper3");
        wr(16, 32'hFFFF_0108, "R12 window 3 plus outside");
        ck(32'h0080_0000, 0, "R12 empty window falls to outside");
        wr(16, 32'hFFFF_0008, "R12 window 3 only");
        ck(32'h0080_0000, 0, "R12 empty window protects nothing");

        // R11: clear and denial in the same cycle
        wr(16, 32'hFFFF_0100, "R11 outside only");
        ck(32'h0900_0000, 0, "R11 set flag");
        step(1, 17, 32'h0001_0001, 1, 32'h0A00_0000, 0, "R11 clear with denial");
        wr(17, 32'h0001_0001, "R11 clear");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit we;
            int wa;
            logic [31:0] wd;
            logic [31:0] ca;
            we = ($urandom_range(0, 9) < 3);
            wa = $urandom_range(0, 17);
            wd = {16'($urandom), 16'($urandom_range(0, 20))};
            if (wa == 16) begin
                wd[9:0] = 10'($urandom);
                wd[9] = ($urandom_range(0, 3) == 0);
            end
            if (wa == 17 && $urandom_range(0, 3) != 0) wd = 32'h0;
            ca = {12'($urandom_range(0, 24)), 20'($urandom)};
            step(we, wa, wd, ($urandom_range(0, 9) < 8), ca, ($urandom_range(0, 3) == 0),
                 "R2 R3 R4 R5 R8 R10 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule